// File: doc/BRIEF.md
# Delayed Process Switch Sequencer

This block carries out a software-initiated change of the current process identifier (a 3-bit value, 0 to 7) with two separately timed commits. Software first stages a target identifier, a PID-commit delay and a mask-release delay through a small register-write port. It can raise a non-maskable-interrupt mask output so that the switch cannot be interrupted. It then writes a confirm command and a mask-release command. Each command starts its own countdown. The identifier changes when the first countdown expires, and the mask drops when the second one expires, so software can time both changes to land on the first instruction of the new process.

Only a privileged process, meaning one whose current identifier is 0 or 1, may start either countdown. An interrupt-entry input has priority over everything else. It forces the identifier to 0 and discards any PID commit still waiting.

Top module: `proc_switch_seq`

## Requirements
- R1: After reset, cur_pid is 0, nmi_mask is 0 and busy is 0.
- R2: Register writes are decoded from wr_addr when wr_en is 1. Address 0 stages the target identifier from wr_data[2:0]. Address 1 sets the PID delay and address 2 sets the release delay, each 8 bits. Address 3 raises the mask, address 4 confirms the switch and address 5 requests the mask release. Each of the three commands acts only when wr_data[0] is 1.
- R3: A confirm with PID delay D sets cur_pid to the staged target on the D-th clock edge after the edge that samples the write. When D is 0, the change happens on the sampling edge itself.
- R4: A mask-raise write sets nmi_mask to 1 on its sampling edge. A release write with delay D clears nmi_mask D edges after its sampling edge, or on that edge when D is 0.
- R5: The two countdowns run independently with different delays. Each output changes only at its own time.
- R6: A confirm or release write made while cur_pid is 2 to 7 is ignored. The identifier, the mask and busy stay as they are.
- R7: A confirm written while a PID countdown is running restarts it. The restarted countdown uses the delay and target staged at the time of the new confirm.
- R8: irq_entry=1 sets cur_pid to 0 on the next edge and cancels a pending PID commit. It takes priority over a confirm on the same edge.
- R9: busy is 1 exactly while either countdown is running.
- R10: A mask-raise write while a release countdown is running cancels the release, and nmi_mask stays 1.
- R11: Any target identifier from 0 to 7 can be committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| irq_entry | input | 1 | Interrupt entry; forces identifier 0 |
| cur_pid | output | 3 | Current process identifier |
| nmi_mask | output | 1 | Non-maskable-interrupt mask |
| busy | output | 1 | A countdown is running |

## Verification
Every result has a fixed due time counted from the clock edge that samples the stimulus, which is called edge zero. The identifier is due at edge D of the PID delay. The mask drop is due at edge D of the release delay, counted from its own write. A mask raise and an interrupt entry are due at edge zero. busy reflects a counter that is loaded at edge zero. Stimulus is applied at falling edges and every output is read at the falling edge after each rising edge, so the bench can tag each observation with its distance t from edge zero. It then compares against the value that the delay arithmetic predicts for that t, one check per cycle. This covers the cycles both before and after each change, so an early or late commit is caught.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int PID_W  = 3;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  // register map (address decoding)
  localparam logic [ADDR_W-1:0] A_TARGET  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PID_DLY = 3'd1;
  localparam logic [ADDR_W-1:0] A_NMI_DLY = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK_ON = 3'd3;
  localparam logic [ADDR_W-1:0] A_CONFIRM = 3'd4;
  localparam logic [ADDR_W-1:0] A_RELEASE = 3'd5;

  // privileged processes may start a switch
  function automatic logic is_privileged(input logic [PID_W-1:0] pid);
    return pid <= PID_W'(1);
  endfunction

  // countdown is on its final cycle
  function automatic logic on_last(input logic act, input logic [31:0] cnt);
    return act && (cnt == 32'd1);
  endfunction

  // a start with zero delay commits at once
  function automatic logic commits_now(input logic [31:0] load);
    return load == 32'd0;
  endfunction
endpackage

// File: rtl/pss_regfile.sv
module pss_regfile #(
  parameter int PID_W  = 3,
  parameter int DLY_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PID_W-1:0]  target_pid,
  output logic [DLY_W-1:0]  pid_dly,
  output logic [DLY_W-1:0]  nmi_dly
);
  import pss_pkg::*;

  logic sel_target, sel_pid_dly, sel_nmi_dly;
  assign sel_target  = wr_en && (wr_addr == A_TARGET);
  assign sel_pid_dly = wr_en && (wr_addr == A_PID_DLY);
  assign sel_nmi_dly = wr_en && (wr_addr == A_NMI_DLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_pid <= '0;
      pid_dly    <= '0;
      nmi_dly    <= '0;
    end else begin
      if (sel_target)  target_pid <= wr_data[PID_W-1:0];
      if (sel_pid_dly) pid_dly    <= wr_data[DLY_W-1:0];
      if (sel_nmi_dly) nmi_dly    <= wr_data[DLY_W-1:0];
    end
  end

  // R2
  target_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_target |=> target_pid == $past(wr_data[PID_W-1:0]));
endmodule

// File: rtl/pss_countdown.sv
module pss_countdown #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic [DLY_W-1:0] load,
  output logic             fire,
  output logic             active
);
  import pss_pkg::*;

  logic [DLY_W-1:0] cnt_q;
  logic             act_q;
  logic             last_cyc;
  logic             zero_start;

  assign last_cyc   = on_last(act_q, 32'(cnt_q));
  assign zero_start = start && commits_now(32'(load));
  assign fire       = !cancel && (zero_start || (!start && last_cyc));
  assign active     = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cancel) begin
      act_q <= 1'b0;
    end else if (start) begin
      act_q <= !zero_start;
      cnt_q <= load;
    end else if (act_q) begin
      if (last_cyc) act_q <= 1'b0;
      cnt_q <= cnt_q - DLY_W'(1);
    end
  end

  // R9
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cancel && load != '0) |=> active);
  // R9
  expire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && !start && !cancel) |=> !active);
  // R8
  cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !active);
endmodule

// File: rtl/proc_switch_seq.sv
module proc_switch_seq #(
  parameter int PID_W  = 3,
  parameter int DLY_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_entry,
  output logic [PID_W-1:0]  cur_pid,
  output logic              nmi_mask,
  output logic              busy
);
  import pss_pkg::*;

  logic [PID_W-1:0] target_pid, pid_target_q, commit_val, cur_pid_q;
  logic [DLY_W-1:0] pid_dly, nmi_dly;
  logic             nmi_mask_q;
  logic             privileged;
  logic             confirm_try, release_try, confirm_wr, release_wr, mask_set_wr;
  logic             pid_fire, pid_active, nmi_fire, nmi_active;

  pss_regfile #(.PID_W(PID_W), .DLY_W(DLY_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .target_pid(target_pid), .pid_dly(pid_dly), .nmi_dly(nmi_dly));

  // command decode
  assign privileged  = is_privileged(cur_pid_q);
  assign confirm_try = wr_en && (wr_addr == A_CONFIRM) && wr_data[0];
  assign release_try = wr_en && (wr_addr == A_RELEASE) && wr_data[0];
  assign mask_set_wr = wr_en && (wr_addr == A_MASK_ON) && wr_data[0];
  assign confirm_wr  = confirm_try && privileged;
  assign release_wr  = release_try && privileged;

  pss_countdown #(.DLY_W(DLY_W)) u_pid_cd (
    .clk(clk), .rst_n(rst_n), .start(confirm_wr), .cancel(irq_entry),
    .load(pid_dly), .fire(pid_fire), .active(pid_active));

  pss_countdown #(.DLY_W(DLY_W)) u_nmi_cd (
    .clk(clk), .rst_n(rst_n), .start(release_wr), .cancel(mask_set_wr),
    .load(nmi_dly), .fire(nmi_fire), .active(nmi_active));

  // target snapshot taken at confirm; a zero-delay confirm uses it directly
  assign commit_val = confirm_wr ? target_pid : pid_target_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_target_q <= '0;
      cur_pid_q    <= '0;
      nmi_mask_q   <= 1'b0;
    end else begin
      if (confirm_wr) pid_target_q <= target_pid;
      if (irq_entry)     cur_pid_q <= '0;
      else if (pid_fire) cur_pid_q <= commit_val;
      if (mask_set_wr)   nmi_mask_q <= 1'b1;
      else if (nmi_fire) nmi_mask_q <= 1'b0;
    end
  end

  assign cur_pid  = cur_pid_q;
  assign nmi_mask = nmi_mask_q;
  assign busy     = pid_active || nmi_active;

  // R8
  irq_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> cur_pid == '0);
  // R6
  unpriv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (confirm_try && !privileged && !pid_active && !irq_entry) |=> $stable(cur_pid));
  // R4
  mask_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set_wr |=> nmi_mask);
  // R4
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_fire |=> !nmi_mask);
  // R3
  pid_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pid_fire |=> cur_pid == $past(commit_val));
endmodule

// File: tb/sim_proc_switch_seq.sv
module sim_proc_switch_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq_entry = 1'b0;
  logic [2:0] cur_pid;
  logic       nmi_mask, busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  proc_switch_seq u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_entry(irq_entry), .cur_pid(cur_pid), .nmi_mask(nmi_mask), .busy(busy));

  // vector: {pid delay, release delay, target}
  localparam int NV = 7;
  localparam logic [18:0] VEC [NV] = '{
    {8'd0,   8'd0, 3'd1}, {8'd3, 8'd1, 3'd2}, {8'd1, 8'd6, 3'd7},
    {8'd10,  8'd2, 3'd4}, {8'd5, 8'd5, 3'd3}, {8'd255, 8'd3, 3'd5},
    {8'd2,   8'd0, 3'd6}};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller is at a falling edge; returns one falling edge after the sampling edge (t=0)
  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic irq_pulse();
    irq_entry = 1'b1;
    @(negedge clk);
    irq_entry = 1'b0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    step(2);
    // R1 reset state
    check("R1 pid", cur_pid, 0);
    check("R1 mask", nmi_mask, 0);
    check("R1 busy", busy, 0);
    rst_n = 1'b1;
    step(1);

    // vector walk: R2 R3 R4 R5 R9 R11
    for (int v = 0; v < NV; v++) begin
      int d1, d2, np, tmax;
      d1 = int'(VEC[v][18:11]); d2 = int'(VEC[v][10:3]); np = int'(VEC[v][2:0]);
      tmax = ((d1 > d2 + 1) ? d1 : d2 + 1) + 2;
      wr(0, np); wr(1, d1); wr(2, d2); wr(3, 1);
      check("R4 mask raised", nmi_mask, 1);
      wr(4, 1);
      for (int t = 0; t <= tmax; t++) begin
        check("R3 R11 pid", cur_pid, (t >= d1) ? np : 0);
        check("R4 R5 mask", nmi_mask, (t >= d2 + 1) ? 0 : 1);
        check("R9 busy", busy, ((t < d1) || (t >= 1 && t < d2 + 1)) ? 1 : 0);
        if (t == 0) begin
          wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'd1;
        end else wr_en = 1'b0;
        @(negedge clk);
      end
      irq_pulse();
      check("R8 pid after irq", cur_pid, 0);
    end

    // R6: unprivileged confirm and release are ignored
    wr(0, 5); wr(1, 0); wr(4, 1);
    check("R6 setup pid", cur_pid, 5);
    wr(0, 2); wr(3, 1); wr(2, 0);
    wr(4, 1);
    step(3);
    check("R6 pid kept", cur_pid, 5);
    wr(5, 1);
    step(3);
    check("R6 mask kept", nmi_mask, 1);
    check("R6 busy", busy, 0);
    irq_pulse();

    // R7: reconfirm restarts with current delay and target
    wr(0, 3); wr(1, 5); wr(4, 1);
    step(1);
    wr(0, 6); wr(1, 4);
    wr(4, 1);
    for (int t = 0; t < 4; t++) begin
      check("R7 pid held", cur_pid, 0);
      @(negedge clk);
    end
    check("R7 pid restarted", cur_pid, 6);
    irq_pulse();

    // R8: irq cancels pending commit and beats a same-edge confirm
    wr(0, 4); wr(1, 4); wr(4, 1);
    irq_pulse();
    step(6);
    check("R8 cancelled", cur_pid, 0);
    check("R8 busy", busy, 0);
    wr(1, 0);
    irq_entry = 1'b1; wr(4, 1); irq_entry = 1'b0;
    check("R8 priority", cur_pid, 0);

    // R10: mask raise cancels a pending release
    wr(3, 1); wr(2, 6); wr(5, 1);
    step(2);
    wr(3, 1);
    step(8);
    check("R10 mask held", nmi_mask, 1);
    check("R10 busy", busy, 0);

    // R2: command with data bit 0 clear does nothing
    wr(5, 0);
    step(2);
    check("R2 no release", nmi_mask, 1);

    finish_run();
  end
endmodule